// File: doc/BRIEF.md
# Backplane Bus Requester with Selectable Release Policy

This block requests and gives back a shared multi-master backplane for one board. When local logic has transfers to run, the block drives one of four request lines. It then waits for the system arbiter's grant and asserts busy for as long as it owns the bus. A new local transfer that arrives while the bus is still owned runs at once, with no new request.

The moment of release is set by a policy input. Under release when done, the bus goes back as soon as local activity stops. Under release on request, the bus is kept until some other master raises a request. Under release after timeout, the bus is kept for a programmable hold time after the last local transfer.

A lock input overrides every policy and keeps the bus owned. Software that emulates an atomic read followed by a write raises the lock, so the whole backplane acts as a global semaphore for that pair.

Top module: `busRequester`

## Requirements
- R1: During and after reset the block is idle: `busReqOut` is all zero and `busBusy` is low.
- R2: Local activity (`xferActive` high) in the idle state drives exactly one request line one cycle later. Bit n of `busReqOut` stands for level n. The level is `cfgLevel` when `cfgLevelEn` is high and level 3 when it is low. The level is latched at the start of each request.
- R3: A grant sampled while requesting asserts `busBusy` one cycle later and drops the request line in the same cycle.
- R4: With `policy` = 0 (release when done), or with the unused code 3, `busBusy` falls one cycle after the first cycle in which `xferActive` and `lockIn` are both low.
- R5: With `policy` = 1 (release on request), an owned bus is kept while `otherReq` is all zero. It is given back one cycle after a cycle in which some `otherReq` bit is high and `xferActive` and `lockIn` are low.
- R6: With `policy` = 2 (release after timeout), the hold counter reloads from `holdReload` every cycle that `xferActive` is high. `busBusy` falls H+1 cycles after the first cycle with `xferActive` low, where H is the reload value, unless a new transfer restarts the count.
- R7: While `lockIn` is high, an owned bus is never given back, under any policy. Release is judged again in the first cycle the lock is low.
- R8: A local transfer that starts while the bus is owned raises no request line, and `busBusy` stays high.
- R9: A grant seen while the block is not requesting has no effect: `busBusy` stays low and no request line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLevelEn | input | 1 | Use `cfgLevel` instead of the default level 3 |
| cfgLevel | input | 2 | Configured request level |
| policy | input | 2 | Release policy: 0 done, 1 on request, 2 timeout, 3 as 0 |
| holdReload | input | 16 | Hold time in cycles for the timeout policy |
| xferActive | input | 1 | Local transfers pending or running |
| lockIn | input | 1 | Keep the bus owned across an atomic read-write pair |
| busGrant | input | 1 | Grant from the arbiter for this board |
| otherReq | input | 4 | Request lines raised by other masters |
| busReqOut | output | 4 | One-hot request line drive |
| busBusy | output | 1 | Bus owned by this board |

## Verification
Two events can fall in the same cycle: the release decision (the transfer ending, a foreign request, or the hold timer reaching zero) and either a lock or a new local transfer that must cancel it. The bench drives these together on purpose. It raises a foreign request in the same cycle a new local transfer starts under release on request. It lets the transfer end in the same cycle the lock is already high, under both the done and the timeout policies. The correct result is that busy stays high and no request line is raised. Release is then expected exactly one cycle after the blocking condition clears. A random phase mixes the same events freely and compares every cycle against a bench model.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

  typedef enum logic [1:0] {
    REL_DONE    = 2'd0,
    REL_ON_REQ  = 2'd1,
    REL_TIMEOUT = 2'd2,
    REL_SPARE   = 2'd3
  } relPolicy_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } ownState_t;

  typedef struct packed {
    logic latchLevel;
    logic driveReq;
    logic timerLoad;
  } ctrlStrobe_t;

endpackage

// File: rtl/busReqPath.sv
module busReqPath
  import busreq_pkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int DEFAULT_LEVEL = 3,
  parameter int TIMER_W       = 16,
  localparam int LEVEL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  cfgLevelEn,
  input  logic [LEVEL_W-1:0]    cfgLevel,
  input  logic [TIMER_W-1:0]    holdReload,
  input  logic [NUM_LEVELS-1:0] otherReq,
  output logic [NUM_LEVELS-1:0] busReqOut,
  output logic                  timerZero,
  output logic                  anyOther
);

  logic [LEVEL_W-1:0] levelReg;
  logic [TIMER_W-1:0] timerCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelReg <= LEVEL_W'(DEFAULT_LEVEL);
    end else if (strobe.latchLevel) begin
      levelReg <= cfgLevelEn ? cfgLevel : LEVEL_W'(DEFAULT_LEVEL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (strobe.timerLoad) begin
      timerCnt <= holdReload;
    end else if (timerCnt != '0) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gReqLine
    assign busReqOut[g] = strobe.driveReq && (levelReg == LEVEL_W'(g));
  end

  assign timerZero = (timerCnt == '0);
  assign anyOther  = |otherReq;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busReqOut)); // R2

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.timerLoad |=> (timerCnt == $past(holdReload))); // R6

endmodule

// File: rtl/busReqCtrl.sv
module busReqCtrl
  import busreq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferActive,
  input  logic        lockIn,
  input  logic        busGrant,
  input  logic        othersReq,
  input  logic        timerZero,
  input  logic [1:0]  policy,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  ownState_t  state, stateNext;
  relPolicy_t pol;
  logic       releaseNow;

  assign pol = relPolicy_t'(policy);

  always_comb begin
    releaseNow = 1'b0;
    if (state == ST_OWN && !lockIn && !xferActive) begin
      case (pol)
        REL_ON_REQ:  releaseNow = othersReq;
        REL_TIMEOUT: releaseNow = timerZero;
        default:     releaseNow = 1'b1;
      endcase
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (xferActive) stateNext = ST_WAIT;
      ST_WAIT: if (busGrant)   stateNext = ST_OWN;
      ST_OWN:  if (releaseNow) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.latchLevel = (state == ST_IDLE) && xferActive;
    strobe.driveReq   = (state == ST_WAIT);
    strobe.timerLoad  = xferActive;
  end

  assign busy = (state == ST_OWN);

  AST_GRANT_TO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && busGrant) |=> busy); // R3

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && policy == 2'd0 && !xferActive && !lockIn) |=> !busy); // R4

  AST_ROR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && policy == 2'd1 && !othersReq) |=> busy); // R5

  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lockIn) |=> busy); // R7

  AST_STRAY_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !xferActive && busGrant) |=> !busy); // R9

endmodule

// File: rtl/busRequester.sv
module busRequester
  import busreq_pkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int DEFAULT_LEVEL = 3,
  parameter int TIMER_W       = 16,
  localparam int LEVEL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgLevelEn,
  input  logic [LEVEL_W-1:0]    cfgLevel,
  input  logic [1:0]            policy,
  input  logic [TIMER_W-1:0]    holdReload,
  input  logic                  xferActive,
  input  logic                  lockIn,
  input  logic                  busGrant,
  input  logic [NUM_LEVELS-1:0] otherReq,
  output logic [NUM_LEVELS-1:0] busReqOut,
  output logic                  busBusy
);

  ctrlStrobe_t strobe;
  logic        timerZero;
  logic        anyOther;

  busReqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .lockIn     (lockIn),
    .busGrant   (busGrant),
    .othersReq  (anyOther),
    .timerZero  (timerZero),
    .policy     (policy),
    .strobe     (strobe),
    .busy       (busBusy)
  );

  busReqPath #(
    .NUM_LEVELS    (NUM_LEVELS),
    .DEFAULT_LEVEL (DEFAULT_LEVEL),
    .TIMER_W       (TIMER_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgLevelEn (cfgLevelEn),
    .cfgLevel   (cfgLevel),
    .holdReload (holdReload),
    .otherReq   (otherReq),
    .busReqOut  (busReqOut),
    .timerZero  (timerZero),
    .anyOther   (anyOther)
  );

  AST_NO_REREQ_WHILE_OWN: assert property (@(posedge clk) disable iff (!rstN)
    busBusy |-> (busReqOut == '0)); // R8

endmodule

// File: tb/busRequester_test.sv
module busRequester_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLevelEn = 1'b0;
  logic [1:0]  cfgLevel = 2'd0;
  logic [1:0]  policy = 2'd0;
  logic [15:0] holdReload = 16'd0;
  logic        xferActive = 1'b0;
  logic        lockIn = 1'b0;
  logic        busGrant = 1'b0;
  logic [3:0]  otherReq = 4'd0;
  logic [3:0]  busReqOut;
  logic        busBusy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  busRequester uut (
    .clk(clk), .rstN(rstN), .cfgLevelEn(cfgLevelEn), .cfgLevel(cfgLevel),
    .policy(policy), .holdReload(holdReload), .xferActive(xferActive),
    .lockIn(lockIn), .busGrant(busGrant), .otherReq(otherReq),
    .busReqOut(busReqOut), .busBusy(busBusy)
  );

  // Reference model built from the requirements: 0 idle, 1 requesting, 2 owning
  int         mState = 0;
  logic [1:0] mLevel = 2'd3;
  int         mTimer = 0;

  function automatic bit relDecision(int st, int tmr, logic [1:0] pol,
                                     logic xf, logic lk, logic [3:0] oth);
    if (st != 2 || xf || lk) return 1'b0;
    if (pol == 2'd1) return |oth;
    if (pol == 2'd2) return tmr == 0;
    return 1'b1;
  endfunction

  function automatic logic [3:0] expReq(int st, logic [1:0] lvl);
    return (st == 1) ? (4'b0001 << lvl) : 4'b0000;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState <= 0; mLevel <= 2'd3; mTimer <= 0;
    end else begin
      if (mState == 0 && xferActive) begin
        mState <= 1;
        mLevel <= cfgLevelEn ? cfgLevel : 2'd3;
      end else if (mState == 1 && busGrant) begin
        mState <= 2;
      end else if (relDecision(mState, mTimer, policy, xferActive, lockIn, otherReq)) begin
        mState <= 0;
      end
      if (xferActive) mTimer <= int'(holdReload);
      else if (mTimer != 0) mTimer <= mTimer - 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkBusy(string tag, logic exp);
    check(busBusy == exp, tag, int'(busBusy), int'(exp));
  endtask

  task automatic checkReq(string tag, logic [3:0] exp);
    check(busReqOut == exp, tag, int'(busReqOut), int'(exp));
  endtask

  task automatic acquire();
    xferActive = 1'b1;
    tick();
    busGrant = 1'b1;
    tick();
    busGrant = 1'b0;
    checkBusy("R3 acquire busy", 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    @(negedge clk);
    xferActive = 1'b1;
    tick();
    checkBusy("R1 busy in reset", 1'b0);
    checkReq("R1 request in reset", 4'b0000);
    xferActive = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    checkBusy("R1 busy after reset", 1'b0);
    checkReq("R1 request after reset", 4'b0000);

    // R9: grant without a request
    busGrant = 1'b1;
    repeat (3) tick();
    checkBusy("R9 stray grant busy", 1'b0);
    checkReq("R9 stray grant request", 4'b0000);
    busGrant = 1'b0;

    // R2 default level, R3 grant to busy, R4 release when done
    xferActive = 1'b1;
    tick();
    checkReq("R2 default level 3", 4'b1000);
    busGrant = 1'b1;
    tick();
    busGrant = 1'b0;
    checkBusy("R3 busy after grant", 1'b1);
    checkReq("R3 request dropped", 4'b0000);
    xferActive = 1'b0;
    tick();
    checkBusy("R4 release when done", 1'b0);

    // R2 configured level
    cfgLevelEn = 1'b1; cfgLevel = 2'd1;
    xferActive = 1'b1;
    tick();
    checkReq("R2 configured level 1", 4'b0010);
    busGrant = 1'b1;
    tick();
    busGrant = 1'b0;
    cfgLevelEn = 1'b0;

    // R5 release on request, with R8 collision
    policy = 2'd1;
    xferActive = 1'b0;
    repeat (5) tick();
    checkBusy("R5 held without foreign request", 1'b1);
    otherReq = 4'b0001; xferActive = 1'b1;
    tick();
    checkBusy("R8 new transfer beats foreign request", 1'b1);
    checkReq("R8 no request while owned", 4'b0000);
    tick();
    checkReq("R8 still no request", 4'b0000);
    xferActive = 1'b0;
    tick();
    checkBusy("R5 released on foreign request", 1'b0);
    otherReq = 4'b0000;

    // R6 release after timeout
    policy = 2'd2; holdReload = 16'd4;
    acquire();
    xferActive = 1'b0;
    repeat (4) tick();
    checkBusy("R6 held during hold time", 1'b1);
    tick();
    checkBusy("R6 released after hold time", 1'b0);
    acquire();
    xferActive = 1'b0;
    repeat (2) tick();
    xferActive = 1'b1;
    tick();
    checkReq("R8 restart transfer no request", 4'b0000);
    xferActive = 1'b0;
    repeat (4) tick();
    checkBusy("R6 restarted hold time", 1'b1);
    tick();
    checkBusy("R6 released after restarted hold", 1'b0);

    // R7 lock overrides release when done
    policy = 2'd0; lockIn = 1'b1;
    acquire();
    xferActive = 1'b0;
    repeat (3) tick();
    checkBusy("R7 lock holds done policy", 1'b1);
    lockIn = 1'b0;
    tick();
    checkBusy("R7 release after lock drops", 1'b0);

    // R7 lock overrides timeout expiry
    policy = 2'd2; holdReload = 16'd1; lockIn = 1'b1;
    acquire();
    xferActive = 1'b0;
    repeat (5) tick();
    checkBusy("R7 lock holds past timeout", 1'b1);
    lockIn = 1'b0;
    tick();
    checkBusy("R7 timeout release after lock", 1'b0);

    // Random phase compared cycle by cycle to the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 0) begin
        policy = 2'($urandom % 4);
        holdReload = 16'($urandom % 8);
      end
      xferActive = ($urandom % 3) == 0;
      lockIn = ($urandom % 8) == 0;
      otherReq = (($urandom % 5) == 0) ? 4'($urandom) : 4'd0;
      cfgLevelEn = $urandom % 2;
      cfgLevel = 2'($urandom);
      busGrant = ((busReqOut != 4'd0) && ($urandom % 3 == 0)) || ($urandom % 16 == 0);
      tick();
      check(busBusy == (mState == 2), "R3 random busy", int'(busBusy), int'(mState == 2));
      check(busReqOut == expReq(mState, mLevel), "R2 random request",
            int'(busReqOut), int'(expReq(mState, mLevel)));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule